// File: doc/BRIEF.md
# Conditional Branch Resolver with Static Direction Hint

This block settles an integer conditional branch one cycle after it is presented, and it also issues the static guess that a front end would have made for the same branch. Each request carries five things: a valid strobe, a three-bit condition code, a 64-bit operand read from the register file, the address of the instruction that follows the branch, and a signed 21-bit word displacement. The block then produces the branch target, the actual direction, the guessed direction, a flag that marks a wrong guess, and a flag for an unused condition code.

The guess comes from the displacement alone. A backward branch (negative displacement) is guessed taken. A forward branch, or one with zero displacement, is guessed not taken. The target is computed from the sequential address, not from the branch's own address. The displacement counts 32-bit words, so it is scaled by four before it is added. A later stage that redirects the pipeline reads the wrong-guess flag and the target from the same registered output.

Top module: `br_resolve`

## Requirements
- R1: Condition codes 0 (EQ: operand equal to zero), 1 (GE: operand greater than or equal to zero), 2 (GT: operand greater than zero), 5 (LE: operand less than or equal to zero) and 6 (LT: operand less than zero) give the taken decision from the operand read as a 64-bit two's complement number.
- R2: Condition code 3 (LBC) is taken when operand bit 0 is 0, and code 4 (LBS) is taken when bit 0 is 1. No other operand bit affects these two codes.
- R3: Condition code 7 is reserved. It resolves as not taken and raises out_illegal for that result.
- R4: out_target equals in_npc plus the sign-extended displacement shifted left by two, taken modulo 2^64.
- R5: out_pred_taken is 1 exactly when displacement bit 20 is 1. A zero displacement is guessed not taken.
- R6: out_mispredict is 1 exactly when a result is valid and out_pred_taken differs from out_taken.
- R7: Every result appears one clock after its request: out_valid follows in_valid with a delay of one cycle.
- R8: After a cycle with in_valid low, out_taken, out_pred_taken, out_mispredict and out_illegal are 0, and out_target keeps its previous value.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_cond | input | 3 | Condition code (0 EQ, 1 GE, 2 GT, 3 LBC, 4 LBS, 5 LE, 6 LT, 7 reserved) |
| in_rval | input | 64 | Operand tested by the condition |
| in_npc | input | 64 | Address of the instruction after the branch |
| in_disp | input | 21 | Signed word displacement |
| out_valid | output | 1 | Result strobe |
| out_target | output | 64 | Computed branch target |
| out_taken | output | 1 | Actual direction |
| out_pred_taken | output | 1 | Static guess from the displacement sign |
| out_mispredict | output | 1 | Guess differs from the actual direction |
| out_illegal | output | 1 | Reserved condition code seen |

## Verification
The wrong-guess flag and the reserved-code flag can both be raised by one result. A request with code 7 and a negative displacement is guessed taken but resolves as not taken. The bench sends that request and several other reserved-code requests with displacements of both signs. The scoreboard predicts both flags on its own for each of them and requires each flag to match in the same output cycle. A wrapping target on a request that ends in a wrong guess is also checked, so that the adder and the comparison logic are confirmed to update together.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    C_EQ  = 3'd0,
    C_GE  = 3'd1,
    C_GT  = 3'd2,
    C_LBC = 3'd3,
    C_LBS = 3'd4,
    C_LE  = 3'd5,
    C_LT  = 3'd6,
    C_RSV = 3'd7
  } cond_e;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        cond,
  input  logic [DATA_W-1:0] rval,
  output logic              hit,
  output logic              illegal
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (rval == '0);
  assign is_neg  = rval[DATA_W-1];

  always_comb begin
    hit     = 1'b0;
    illegal = 1'b0;
    case (cond_e'(cond))
      C_EQ:    hit = is_zero;
      C_GE:    hit = !is_neg;
      C_GT:    hit = !is_neg && !is_zero;
      C_LBC:   hit = !rval[0];
      C_LBS:   hit = rval[0];
      C_LE:    hit = is_neg || is_zero;
      C_LT:    hit = is_neg;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int PC_W   = 64,
  parameter int DISP_W = 21
) (
  input  logic [PC_W-1:0]   npc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - DISP_W - 2;

  function automatic logic [PC_W-1:0] byte_offset(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d, 2'b00};
  endfunction

  assign target = npc + byte_offset(disp);
endmodule

// File: rtl/br_hint.sv
module br_hint #(
  parameter int DISP_W = 21
) (
  input  logic [DISP_W-1:0] disp,
  output logic              backward
);
  assign backward = disp[DISP_W-1];
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PC_W   = 64,
  parameter int DISP_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_cond,
  input  logic [DATA_W-1:0] in_rval,
  input  logic [PC_W-1:0]   in_npc,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_target,
  output logic              out_taken,
  output logic              out_pred_taken,
  output logic              out_mispredict,
  output logic              out_illegal
);
  logic            cond_hit;
  logic            cond_illegal;
  logic            hint_back;
  logic [PC_W-1:0] calc_target;
  logic            guess_wrong;

  br_cond_eval #(.DATA_W(DATA_W)) u_eval (
    .cond    (in_cond),
    .rval    (in_rval),
    .hit     (cond_hit),
    .illegal (cond_illegal)
  );

  br_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .npc    (in_npc),
    .disp   (in_disp),
    .target (calc_target)
  );

  br_hint #(.DISP_W(DISP_W)) u_hint (
    .disp     (in_disp),
    .backward (hint_back)
  );

  assign guess_wrong = cond_hit ^ hint_back;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_target     <= '0;
      out_taken      <= 1'b0;
      out_pred_taken <= 1'b0;
      out_mispredict <= 1'b0;
      out_illegal    <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      out_taken      <= in_valid & cond_hit;
      out_pred_taken <= in_valid & hint_back;
      out_mispredict <= in_valid & guess_wrong;
      out_illegal    <= in_valid & cond_illegal;
      if (in_valid) out_target <= calc_target;
    end
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int DATA_W = 64,
  parameter int PC_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_cond,
  input logic [DATA_W-1:0] in_rval,
  input logic              in_disp_msb,
  input logic              out_valid,
  input logic [PC_W-1:0]   out_target,
  input logic              out_taken,
  input logic              out_pred_taken,
  input logic              out_mispredict,
  input logic              out_illegal
);
  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R6
  mispredict_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mispredict == (out_pred_taken != out_taken)));

  // R3
  reserved_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!out_taken && out_valid));

  // R5
  hint_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pred_taken == $past(in_disp_msb)));

  // R8
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_taken || out_pred_taken || out_mispredict || out_illegal));

  // R8
  idle_target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_target));

  // R1
  eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_cond) == 3'd0) |-> (out_taken == ($past(in_rval) == '0)));

  // R2
  lbs_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_cond) == 3'd4) |-> (out_taken == $past(in_rval[0])));
endmodule

bind br_resolve br_resolve_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_cond        (in_cond),
  .in_rval        (in_rval),
  .in_disp_msb    (in_disp[DISP_W-1]),
  .out_valid      (out_valid),
  .out_target     (out_target),
  .out_taken      (out_taken),
  .out_pred_taken (out_pred_taken),
  .out_mispredict (out_mispredict),
  .out_illegal    (out_illegal)
);

// File: tb/br_resolve_test.sv
module br_resolve_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] target;
    logic        taken;
    logic        pred;
    logic        illegal;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_cond = '0;
  logic [63:0] in_rval = '0;
  logic [63:0] in_npc = '0;
  logic [20:0] in_disp = '0;
  logic        out_valid;
  logic [63:0] out_target;
  logic        out_taken;
  logic        out_pred_taken;
  logic        out_mispredict;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  exp_t sb[$];
  logic [63:0] last_target = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  br_resolve uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cond(in_cond),
    .in_rval(in_rval), .in_npc(in_npc), .in_disp(in_disp),
    .out_valid(out_valid), .out_target(out_target), .out_taken(out_taken),
    .out_pred_taken(out_pred_taken), .out_mispredict(out_mispredict),
    .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic taken_ref(input logic [2:0] c, input logic [63:0] v);
    logic signed [63:0] s;
    s = $signed(v);
    case (c)
      3'd0: return s == 0;
      3'd1: return s >= 0;
      3'd2: return s > 0;
      3'd3: return v[0] == 1'b0;
      3'd4: return v[0] == 1'b1;
      3'd5: return s <= 0;
      3'd6: return s < 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input logic [2:0] c, input logic [63:0] v, input logic [63:0] pc, input logic [20:0] d);
    exp_t e;
    logic signed [63:0] off;
    @(negedge clk);
    in_valid = 1'b1; in_cond = c; in_rval = v; in_npc = pc; in_disp = d;
    off = 64'($signed(d)) * 4;
    e.target  = pc + off;
    e.taken   = taken_ref(c, v);
    e.pred    = ($signed(d) < 0);
    e.illegal = (c == 3'd7);
    e.tag     = (c == 3'd7) ? "R3" : ((c == 3'd3 || c == 3'd4) ? "R2" : "R1");
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_cond = 3'd5; in_rval = '1; in_disp = 21'h1FFFFF;
  endtask

  // Monitor: compares one cycle after each request (R7)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected result", 64'(out_valid), 64'd0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(out_taken == e.taken, e.tag, 64'(out_taken), 64'(e.taken));
            check(out_target == e.target, "R4", out_target, e.target);
            check(out_pred_taken == e.pred, "R5", 64'(out_pred_taken), 64'(e.pred));
            check(out_mispredict == (e.pred != e.taken), "R6",
                  64'(out_mispredict), 64'(e.pred != e.taken));
            check(out_illegal == e.illegal, "R3 illegal", 64'(out_illegal), 64'(e.illegal));
            last_target = e.target;
          end
        end else begin
          check(sb.size() == 0, "R7 missing result", 64'(sb.size()), 64'd0);
          check({out_taken, out_pred_taken, out_mispredict, out_illegal} == 4'b0, "R8 flags",
                64'({out_taken, out_pred_taken, out_mispredict, out_illegal}), 64'd0);
          check(out_target == last_target, "R8 target hold", out_target, last_target);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] vals [7];
    logic [20:0] disps [5];
    logic [63:0] pcs [3];
    vals  = '{64'd0, 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
              64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE};
    disps = '{21'h1FFFFF, 21'h000004, 21'h100000, 21'h0FFFFF, 21'h000000};
    pcs   = '{64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs at zero during reset
    check({out_valid, out_taken, out_pred_taken, out_mispredict, out_illegal} == 5'b0,
          "R9 flags", 64'({out_valid, out_taken, out_pred_taken, out_mispredict, out_illegal}), 64'd0);
    check(out_target == 64'd0, "R9 target", out_target, 64'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 R2 R3: every code against every operand, mixed displacements and PCs
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 7; i++) begin
        drive(3'(c), vals[i], pcs[(c + i) % 3] + 64'(i * 16), disps[(c + i) % 5]);
        if (i % 3 == 2) idle();
      end
    end

    // R3 with R6: reserved code, backward displacement -> wrong guess and illegal together
    drive(3'd7, 64'd0, 64'h0000_0000_0000_0100, 21'h1FFFF0);
    // R4: wrap past zero on a backward branch, and past the top on a forward one
    drive(3'd1, 64'd5, 64'h0, 21'h100000);
    drive(3'd6, 64'd5, 64'hFFFF_FFFF_FFFF_FFF8, 21'h000003);
    // R2: upper bits must not matter
    drive(3'd4, 64'hFFFF_FFFF_FFFF_FFFE, 64'h40, 21'h000001);
    drive(3'd3, 64'h8000_0000_0000_0001, 64'h40, 21'h1FFFFE);
    // R8: idle gap keeps target
    repeat (4) idle();
    drive(3'd2, 64'd1, 64'h1234, 21'h000010);
    repeat (3) idle();

    check(sb.size() == 0, "R7 drained", 64'(sb.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule